// File: doc/BRIEF.md
# Host Shared-Memory Access Window

This block gives a 16-bit host bus access to the two private memories of a co-processor: a data store of 16-bit words and an instruction store of 32-bit words. The host never addresses the memories directly. It loads a 32-bit window address as two 16-bit halves, then moves data through a small set of ports. The region is picked by one address bit. A data-store location is addressed by its word index as written. An instruction word at index k is reached with the window address `(k << 2) | (1 << 22)`, and it travels as two 16-bit halves.

An optional auto-step mode moves the window address forward after each complete access, so a block transfer needs the address loaded only once. A destructive port returns a data-store word and leaves zero in its place, which suits mailbox-style counters and flags. Both memories are modelled inside the block as synchronous single-port arrays. Every host read returns its data one cycle after the request.

Top module: `shmem_window`

## Requirements
- R1: After reset the window address is zero, the control bit is zero and `hst_rvalid` is low. Reading port 0, port 1 or port 5 then returns zero.
- R2: Port codes: 0 is the low address half, 1 is the high address half, 2 is the data port, 3 is the instruction low-half port, 4 is read-and-clear and 5 is control (bit 0 is the auto-step enable). A write to port 0 sets address bits 15:0 and a write to port 1 sets bits 31:16. A read of port 0 or 1 returns that half. The next access already uses the new address.
- R3: When address bit 22 is clear, the data port reads or writes the data-store word whose index is the low address bits, with no translation. The store wraps at its depth.
- R4: A read request (`hst_sel` high, `hst_wr` low) raises `hst_rvalid` with the read data exactly one cycle later. A write request never raises `hst_rvalid`.
- R5: When address bit 22 is set, the instruction index is the address shifted right by two. A write to port 3 latches the low half without changing memory. A write to the data port then stores {written value, latched low half} as one 32-bit word.
- R6: When address bit 22 is set, a read of port 3 returns bits 15:0 and a read of the data port returns bits 31:16 of the addressed instruction word.
- R7: A read of port 4 returns the data-store word at the current address and leaves zero in that location. A write to port 4 has no effect.
- R8: With auto-step on, each data-store access (data port with bit 22 clear, or a read of port 4) adds 1 to the address. A data-port access with bit 22 set adds 4. A port 3 access leaves the address unchanged.
- R9: With auto-step off, no data-port, port 3 or port 4 access changes the address, so repeated accesses hit the same location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | Host access request for this cycle |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_port | input | 3 | Port code (see R2) |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Read data, valid with `hst_rvalid` |
| hst_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
The bench builds the block with its defaults: a 64-word data store, a 32-word instruction store and region bit 22. This means a single 16-bit low-address write reaches both the last data-store word and the wrap back to index zero. The instruction index 5 is reached with the high half set to 0x0040. These values make it possible to step across the data-store wrap, to interleave half-word instruction transfers with address readback, and to check that an uncommitted low half leaves the stored word intact.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

   localparam int HOST_W = 16;

   typedef enum logic [2:0] {
      PORT_ADDR_LO = 3'd0,
      PORT_ADDR_HI = 3'd1,
      PORT_DATA    = 3'd2,
      PORT_INS_LO  = 3'd3,
      PORT_RDCLR   = 3'd4,
      PORT_CTRL    = 3'd5
   } win_port_t;

   // source selected for the registered read-data mux
   typedef enum logic [2:0] {
      RSRC_NONE,
      RSRC_REG,
      RSRC_DS,
      RSRC_IS_LO,
      RSRC_IS_HI
   } rd_src_t;

endpackage

// File: rtl/shmem_sram.sv
// Single-port synchronous array, read-before-write, registered read data.
module shmem_sram #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 64,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             en,
   input  logic             we,
   input  logic [AW-1:0]    addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("shmem_sram: DEPTH must be a power of two of at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("shmem_sram: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         rdata <= mem[addr];
         if (we) begin
            mem[addr] <= wdata;
         end
      end
   end

endmodule

// File: rtl/shmem_addr_ctl.sv
// Window address register: halves loaded by the host, optional auto-step.
module shmem_addr_ctl #(
   parameter int HW      = 16,
   parameter int DS_STEP = 1,
   parameter int IS_STEP = 4,
   localparam int AW = 2 * HW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_lo,
   input  logic          ld_hi,
   input  logic [HW-1:0] ld_val,
   input  logic          step_ds,
   input  logic          step_is,
   output logic [AW-1:0] addr
);

   generate
      if (DS_STEP < 1 || IS_STEP < 1) begin : g_bad_step
         $error("shmem_addr_ctl: step sizes must be positive");
      end
   endgenerate

   localparam logic [AW-1:0] DS_INC = AW'(DS_STEP);
   localparam logic [AW-1:0] IS_INC = AW'(IS_STEP);

   logic [AW-1:0] addr_nx;

   always_comb begin
      addr_nx = addr;
      if (ld_lo) begin
         addr_nx[HW-1:0] = ld_val;
      end else if (ld_hi) begin
         addr_nx[AW-1:HW] = ld_val;
      end else if (step_is) begin
         addr_nx = addr + IS_INC;
      end else if (step_ds) begin
         addr_nx = addr + DS_INC;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else begin
         addr <= addr_nx;
      end
   end

   // R2: a low-half load lands in bits 15:0 and keeps the upper half
   a_r2_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lo |=> (addr[HW-1:0] == $past(ld_val)) && (addr[AW-1:HW] == $past(addr[AW-1:HW])));

   // R2: a high-half load lands in bits 31:16 and keeps the lower half
   a_r2_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hi |=> (addr[AW-1:HW] == $past(ld_val)) && (addr[HW-1:0] == $past(addr[HW-1:0])));

   // R9: with no load and no step, the address holds
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_lo || ld_hi || step_ds || step_is) |=> $stable(addr));

   // R8: at most one kind of step per cycle
   a_r8_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_ds && step_is));

endmodule

// File: rtl/shmem_window.sv
module shmem_window
   import shmem_pkg::*;
#(
   parameter int DS_DEPTH = 64,
   parameter int IS_DEPTH = 32,
   parameter int ISEL_BIT = 22,
   localparam int HW    = HOST_W,
   localparam int AW    = 2 * HW,
   localparam int IW    = 2 * HW,
   localparam int DS_AW = $clog2(DS_DEPTH),
   localparam int IS_AW = $clog2(IS_DEPTH),
   localparam int IS_SH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hst_sel,
   input  logic          hst_wr,
   input  logic [2:0]    hst_port,
   input  logic [HW-1:0] hst_wdata,
   output logic [HW-1:0] hst_rdata,
   output logic          hst_rvalid
);

   generate
      if (ISEL_BIT >= AW) begin : g_bad_sel
         $error("shmem_window: ISEL_BIT outside the window address");
      end
      if (IS_AW + IS_SH > ISEL_BIT) begin : g_bad_is
         $error("shmem_window: instruction index overlaps the region bit");
      end
      if (DS_AW > ISEL_BIT) begin : g_bad_ds
         $error("shmem_window: data index overlaps the region bit");
      end
   endgenerate

   win_port_t port;
   logic [AW-1:0] addr;
   logic          ainc_q;
   logic [HW-1:0] lo_hold_q;
   logic          in_is;
   logic          wr_req, rd_req;

   assign port   = win_port_t'(hst_port);
   assign wr_req = hst_sel && hst_wr;
   assign rd_req = hst_sel && !hst_wr;
   assign in_is  = addr[ISEL_BIT];

   // ---------------- address register ----------------
   logic step_ds, step_is;

   assign step_ds = ainc_q && ((hst_sel && port == PORT_DATA && !in_is) ||
                               (rd_req && port == PORT_RDCLR));
   assign step_is = ainc_q && hst_sel && port == PORT_DATA && in_is;

   shmem_addr_ctl #(
      .HW      (HW),
      .DS_STEP (1),
      .IS_STEP (1 << IS_SH)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_lo   (wr_req && port == PORT_ADDR_LO),
      .ld_hi   (wr_req && port == PORT_ADDR_HI),
      .ld_val  (hst_wdata),
      .step_ds (step_ds),
      .step_is (step_is),
      .addr    (addr)
   );

   // ---------------- control and low-half latch ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ainc_q    <= 1'b0;
         lo_hold_q <= '0;
      end else begin
         if (wr_req && port == PORT_CTRL) begin
            ainc_q <= hst_wdata[0];
         end
         if (wr_req && port == PORT_INS_LO) begin
            lo_hold_q <= hst_wdata;
         end
      end
   end

   // ---------------- data store ----------------
   logic             ds_en, ds_we;
   logic [HW-1:0]    ds_wdata, ds_rdata;
   logic [DS_AW-1:0] ds_idx;

   assign ds_idx   = addr[DS_AW-1:0];
   assign ds_en    = (hst_sel && port == PORT_DATA && !in_is) ||
                     (rd_req && port == PORT_RDCLR);
   assign ds_we    = (wr_req && port == PORT_DATA && !in_is) ||
                     (rd_req && port == PORT_RDCLR);
   assign ds_wdata = (port == PORT_RDCLR) ? '0 : hst_wdata;

   shmem_sram #(.WIDTH(HW), .DEPTH(DS_DEPTH)) u_ds (
      .clk   (clk),
      .en    (ds_en),
      .we    (ds_we),
      .addr  (ds_idx),
      .wdata (ds_wdata),
      .rdata (ds_rdata)
   );

   // ---------------- instruction store ----------------
   logic             is_en, is_we;
   logic [IW-1:0]    is_rdata;
   logic [IS_AW-1:0] is_idx;

   assign is_idx = addr[IS_AW+IS_SH-1:IS_SH];
   assign is_en  = (hst_sel && port == PORT_DATA && in_is) ||
                   (rd_req && port == PORT_INS_LO);
   assign is_we  = wr_req && port == PORT_DATA && in_is;

   shmem_sram #(.WIDTH(IW), .DEPTH(IS_DEPTH)) u_is (
      .clk   (clk),
      .en    (is_en),
      .we    (is_we),
      .addr  (is_idx),
      .wdata ({hst_wdata, lo_hold_q}),
      .rdata (is_rdata)
   );

   // ---------------- read return ----------------
   rd_src_t       src_q;
   logic [HW-1:0] reg_q;
   rd_src_t       src_nx;
   logic [HW-1:0] reg_nx;

   always_comb begin
      src_nx = RSRC_NONE;
      reg_nx = '0;
      if (rd_req) begin
         unique case (port)
            PORT_ADDR_LO: begin src_nx = RSRC_REG; reg_nx = addr[HW-1:0]; end
            PORT_ADDR_HI: begin src_nx = RSRC_REG; reg_nx = addr[AW-1:HW]; end
            PORT_CTRL:    begin src_nx = RSRC_REG; reg_nx = {{(HW-1){1'b0}}, ainc_q}; end
            PORT_DATA:    src_nx = in_is ? RSRC_IS_HI : RSRC_DS;
            PORT_INS_LO:  src_nx = RSRC_IS_LO;
            PORT_RDCLR:   src_nx = RSRC_DS;
            default:      src_nx = RSRC_REG;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= RSRC_NONE;
         reg_q <= '0;
      end else begin
         src_q <= src_nx;
         reg_q <= reg_nx;
      end
   end

   always_comb begin
      unique case (src_q)
         RSRC_REG:   hst_rdata = reg_q;
         RSRC_DS:    hst_rdata = ds_rdata;
         RSRC_IS_LO: hst_rdata = is_rdata[HW-1:0];
         RSRC_IS_HI: hst_rdata = is_rdata[IW-1:HW];
         default:    hst_rdata = '0;
      endcase
   end

   assign hst_rvalid = (src_q != RSRC_NONE);

   // R4: a read request is answered on the next cycle
   a_r4_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> hst_rvalid);

   // R4: nothing but a read request raises the valid
   a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !hst_rvalid);

   // R9: with auto-step off, data-port accesses leave the address alone
   a_r9_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!ainc_q && hst_sel && (port == PORT_DATA || port == PORT_INS_LO ||
                              port == PORT_RDCLR)) |=> $stable(addr));

   // R8: a stepped instruction access moves the address by four
   a_r8_is_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ainc_q && hst_sel && port == PORT_DATA && in_is) |=>
         (addr == $past(addr) + AW'(1 << IS_SH)));

   // R8: a stepped data-store access moves the address by one
   a_r8_ds_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ainc_q && hst_sel && port == PORT_DATA && !in_is) |=>
         (addr == $past(addr) + AW'(1)));

   // R5: a low-half write never writes the instruction array
   a_r5_lo_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && port == PORT_INS_LO) |-> !is_we);

endmodule

// File: tb/shmem_window_bench.sv
`timescale 1ns/100ps
module shmem_window_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_sel = 1'b0;
   logic        hst_wr = 1'b0;
   logic [2:0]  hst_port = 3'd0;
   logic [15:0] hst_wdata = 16'h0;
   logic [15:0] hst_rdata;
   logic        hst_rvalid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   shmem_window u_shmem_window (
      .clk        (clk),
      .rst_n      (rst_n),
      .hst_sel    (hst_sel),
      .hst_wr     (hst_wr),
      .hst_port   (hst_port),
      .hst_wdata  (hst_wdata),
      .hst_rdata  (hst_rdata),
      .hst_rvalid (hst_rvalid)
   );

   // vector: [23:20] requirement, [19] write, [18:16] port, [15:0] write data / expected read
   localparam int NV = 38;
   localparam logic [23:0] VEC [NV] = '{
      24'h8_D0001, // R8  auto-step on
      24'h2_80010, // R2  addr lo = 0x10
      24'h2_90000, // R2  addr hi = 0
      24'h3_A1111, // R3  ds[16]
      24'h3_A2222, // R3  ds[17]
      24'h2_80010, // R2
      24'h3_21111, // R3  read ds[16]
      24'h3_22222, // R3  read ds[17]
      24'h8_00012, // R8  address stepped by one per access
      24'h2_80010, // R2
      24'h7_41111, // R7  read-and-clear ds[16]
      24'h2_80010, // R2
      24'h7_20000, // R7  location left zero
      24'h2_80014, // R2  instruction index 5
      24'h2_90040, // R2  region bit 22
      24'h5_BAAAA, // R5  latch low half
      24'h8_00014, // R8  low half does not step
      24'h5_ABBBB, // R5  commit word
      24'h8_00018, // R8  stepped by four
      24'h2_80014, // R2
      24'h6_3AAAA, // R6  low half read
      24'h6_2BBBB, // R6  high half read
      24'h8_00018, // R8
      24'h2_10040, // R2  high half readback
      24'h9_D0000, // R9  auto-step off
      24'h2_90000, // R2
      24'h2_80003, // R2
      24'h9_A3333, // R9
      24'h9_A4444, // R9  same location
      24'h9_24444, // R9
      24'h9_00003, // R9  address unchanged
      24'h9_50000, // R9  control reads back zero
      24'h2_90040, // R2
      24'h2_80014, // R2
      24'h5_B5555, // R5  latch only
      24'h5_3AAAA, // R5  stored low half intact
      24'h6_2BBBB, // R6
      24'h9_00014  // R9
   };

   task automatic check(input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // one host access; for reads the response is checked one cycle later
   task automatic access(input logic wr, input logic [2:0] port,
                         input logic [15:0] val, input string req);
      @(negedge clk);
      hst_sel   = 1'b1;
      hst_wr    = wr;
      hst_port  = port;
      hst_wdata = wr ? val : 16'h0;
      @(posedge clk);
      @(negedge clk);
      hst_sel = 1'b0;
      hst_wr  = 1'b0;
      if (!wr) begin
         check({req, " valid"}, {15'h0, hst_rvalid}, 16'h1);
         check(req, hst_rdata, val);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      @(negedge clk);
      check("R1 idle valid", {15'h0, hst_rvalid}, 16'h0);
      access(1'b0, 3'd0, 16'h0000, "R1 addr lo");
      access(1'b0, 3'd1, 16'h0000, "R1 addr hi");
      access(1'b0, 3'd5, 16'h0000, "R1 ctrl");

      for (int i = 0; i < NV; i++) begin
         access(VEC[i][19], VEC[i][18:16], VEC[i][15:0],
                $sformatf("R%0d vec %0d", VEC[i][23:20], i));
      end

      // R4: a write gives no read response
      access(1'b1, 3'd5, 16'h0001, "R4");
      check("R4 write no valid", {15'h0, hst_rvalid}, 16'h0);

      // R3 / R8: data-store wrap at the last word
      access(1'b1, 3'd1, 16'h0000, "R3");
      access(1'b1, 3'd0, 16'h003F, "R3");
      access(1'b1, 3'd2, 16'h7777, "R3");
      access(1'b1, 3'd2, 16'h8888, "R3");
      access(1'b0, 3'd0, 16'h0041, "R8 across wrap");
      access(1'b1, 3'd0, 16'h0040, "R3");
      access(1'b0, 3'd2, 16'h8888, "R3 wrapped to index 0");
      access(1'b1, 3'd0, 16'h003F, "R3");
      access(1'b0, 3'd2, 16'h7777, "R3 last word");

      // R7: a write to the clear port changes nothing
      access(1'b1, 3'd0, 16'h0005, "R7");
      access(1'b1, 3'd2, 16'h1234, "R7");
      access(1'b1, 3'd0, 16'h0005, "R7");
      access(1'b1, 3'd4, 16'hFFFF, "R7");
      access(1'b0, 3'd0, 16'h0005, "R7 no step on write");
      access(1'b0, 3'd2, 16'h1234, "R7 word kept");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule